// File: doc/BRIEF.md
# Prefilled Dual-Clock Texture Cache

This block copies a small texture out of external memory into on-chip storage and then serves it, word by word, to a sampler that runs on its own unrelated clock. On the memory-clock side it acts as an AXI read master. Each fill is a fixed series of single-beat wide reads. Every beat is unpacked into consecutive 32-bit words of the cache. The memory side keeps a completion flag, the number of beats and bytes moved, and a count of beats that came back with an error response.

A fill is launched by any change of a level input, so software or a neighbouring block starts a new fill by toggling the input. Edges that arrive while a fill is running are remembered, and one more fill follows. On the sampler side a byte-addressed read port returns the addressed word one clock after the request. A ready flag tells the sampler when a complete texture is present. This flag is the memory-side completion flag carried through a two-flop synchroniser. Storage is filled in full before sampling is meant to start, and it has no tags, no eviction and no write path from the sampler.

Top module: `tex_prefill_cache`

## Requirements
- R1: After reset, load_done, load_beats, load_bytes, load_errs, arvalid, smp_ready and smp_rd_data are all zero, and no read request is issued until load_trig changes.
- R2: A fill issues BEATS (default 8) read requests in order n = 0..BEATS-1. Request n has address SRC_BASE + n*32, arlen = 0, arsize = 5 (32 bytes), arburst = 2'b01 (INCR) and arid = AXI_ID. arvalid stays high with a stable address until arready is seen.
- R3: Every transition of load_trig, rising or falling, starts one fill. An edge that arrives while a fill runs is held and starts one more fill afterwards, so a 0→1→0 pulse produces two fills (2×BEATS requests).
- R4: When the last beat of a fill is stored, load_done asserts, with load_beats = 8 and load_bytes = 256. Starting a fill clears load_done, load_beats and load_bytes.
- R5: Each received beat whose rresp differs from 2'b00 adds one to load_errs. The count is cleared when a fill starts, so a clean fill ends with load_errs = 0.
- R6: Bits [w*32 +: 32] of beat n are stored at word index n*8 + w. A sampler byte address A reads word index (A − LOC_BASE) >> 2, and address bits [1:0] are ignored.
- R7: Reads are registered. smp_rd_data shows the addressed word after the first smp_clk rising edge at which smp_rd_en is high, and it keeps its value while smp_rd_en is low.
- R8: A sampler read whose byte address is below LOC_BASE or at or above LOC_BASE + 256 returns zero.
- R9: smp_ready follows load_done through a two-stage synchroniser in the smp_clk domain. It is therefore low while a new fill is running and high some smp_clk cycles after the fill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Memory-side clock |
| smp_clk | input | 1 | Sampler-side clock, unrelated to mem_clk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| load_trig | input | 1 | Level input; any change starts a fill |
| load_done | output | 1 | Fill complete (memory domain) |
| load_beats | output | 32 | Beats stored by the current or last fill |
| load_bytes | output | 32 | Bytes stored by the current or last fill |
| load_errs | output | 32 | Beats with a non-OKAY response in the current or last fill |
| araddr | output | 32 | Read request address |
| arid | output | 4 | Read request ID (fixed) |
| arlen | output | 8 | Burst length minus one (always 0) |
| arsize | output | 3 | Beat size code (always 5) |
| arburst | output | 2 | Burst type (INCR) |
| arvalid | output | 1 | Read request valid |
| arready | input | 1 | Read request accepted |
| rdata | input | 256 | Read beat data |
| rresp | input | 2 | Read response code |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready, high for the whole fill |
| smp_rd_en | input | 1 | Sampler read request |
| smp_rd_addr | input | 32 | Sampler byte address |
| smp_rd_data | output | 32 | Registered read data |
| smp_ready | output | 1 | Synchronised texture-present flag |

## Verification
The hardest situation to reach from the ports is a second trigger edge that lands while a fill is still running. Both the pending-edge logic and the repeated counter clearing depend on it. The bench raises load_trig and drops it again three memory cycles later, well inside the first request, and then counts the address handshakes the memory model grants. The error path is reached by having that model answer one chosen beat with a slave-error response. The fill after it runs clean, which shows the error count is cleared.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_ADDR = 2'd1,
    FS_DATA = 2'd2
  } fill_st_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

endpackage

// File: rtl/tpc_sync.sv
module tpc_sync (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/tpc_fill_ctrl.sv
module tpc_fill_ctrl
  import tpc_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          CNT_W    = 32,
  parameter int          ID_W     = 4,
  parameter int          BEATS    = 8,
  parameter int          BEAT_W   = 256,
  parameter logic [31:0] SRC_BASE = 32'h0010_0000,
  parameter int          AXI_ID   = 0,
  localparam int         BEAT_B   = BEAT_W / 8,
  localparam int         BIW      = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  output logic              done,
  output logic [CNT_W-1:0]  beats,
  output logic [CNT_W-1:0]  bytes,
  output logic [CNT_W-1:0]  errs,
  output logic [ADDR_W-1:0] araddr,
  output logic [ID_W-1:0]   arid,
  output logic [7:0]        arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  output logic              arvalid,
  input  logic              arready,
  input  logic              rvalid,
  input  logic [1:0]        rresp,
  output logic              rready,
  output logic              wr_en,
  output logic [BIW-1:0]    wr_beat
);

  fill_st_e         st_q, st_d;
  logic             trig_q, trig_prev_q;
  logic             pend_q, pend_d;
  logic [BIW-1:0]   bidx_q, bidx_d;
  logic             done_d;
  logic [CNT_W-1:0] beats_d, bytes_d, errs_d;
  logic             edge_seen, start, take, last_beat;

  assign edge_seen = trig_q ^ trig_prev_q;
  assign start     = (st_q == FS_IDLE) && (edge_seen || pend_q);
  assign take      = (st_q == FS_DATA) && rvalid;
  assign last_beat = (bidx_q == BIW'(BEATS - 1));

  always_comb begin
    st_d    = st_q;
    bidx_d  = bidx_q;
    done_d  = done;
    beats_d = beats;
    bytes_d = bytes;
    errs_d  = errs;
    pend_d  = start ? 1'b0 : (pend_q | edge_seen);
    unique case (st_q)
      FS_IDLE: if (start) begin
        st_d    = FS_ADDR;
        bidx_d  = '0;
        done_d  = 1'b0;
        beats_d = '0;
        bytes_d = '0;
        errs_d  = '0;
      end
      FS_ADDR: if (arready) st_d = FS_DATA;
      FS_DATA: if (rvalid) begin
        beats_d = beats + CNT_W'(1);
        bytes_d = bytes + CNT_W'(BEAT_B);
        if (rresp != RESP_OKAY) errs_d = errs + CNT_W'(1);
        if (last_beat) begin
          st_d   = FS_IDLE;
          done_d = 1'b1;
        end else begin
          st_d   = FS_ADDR;
          bidx_d = bidx_q + BIW'(1);
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= FS_IDLE;
      trig_q      <= 1'b0;
      trig_prev_q <= 1'b0;
      pend_q      <= 1'b0;
      bidx_q      <= '0;
      done        <= 1'b0;
      beats       <= '0;
      bytes       <= '0;
      errs        <= '0;
    end else begin
      st_q        <= st_d;
      trig_q      <= trig;
      trig_prev_q <= trig_q;
      pend_q      <= pend_d;
      bidx_q      <= bidx_d;
      done        <= done_d;
      beats       <= beats_d;
      bytes       <= bytes_d;
      errs        <= errs_d;
    end
  end

  assign arvalid = (st_q == FS_ADDR);
  assign araddr  = ADDR_W'(SRC_BASE) + ADDR_W'(bidx_q) * ADDR_W'(BEAT_B);
  assign arid    = ID_W'(AXI_ID);
  assign arlen   = 8'd0;
  assign arsize  = 3'($clog2(BEAT_B));
  assign arburst = BURST_INCR;
  assign rready  = (st_q != FS_IDLE);
  assign wr_en   = take;
  assign wr_beat = bidx_q;

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr))); // R2

  AST_DONE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (beats == CNT_W'(BEATS) && bytes == CNT_W'(BEATS * BEAT_B))); // R4

  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    beats <= CNT_W'(BEATS)); // R4

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (errs != $past(errs)) |-> (errs == $past(errs) + CNT_W'(1) || errs == '0)); // R5

endmodule

// File: rtl/tpc_word_ram.sv
module tpc_word_ram #(
  parameter int          BEATS    = 8,
  parameter int          BEAT_W   = 256,
  parameter int          WORD_W   = 32,
  parameter logic [31:0] LOC_BASE = 32'h0000_0800,
  localparam int         LANES    = BEAT_W / WORD_W,
  localparam int         LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int         BIW      = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int         WB_SH    = $clog2(WORD_W / 8),
  localparam int         TOT_B    = BEATS * BEAT_W / 8
) (
  input  logic              wclk,
  input  logic              wr_en,
  input  logic [BIW-1:0]    wr_beat,
  input  logic [BEAT_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [31:0]       rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [31:0]       off;
  logic [31:0]       widx;
  logic              in_rng;
  logic [BIW-1:0]    rbeat;
  logic [LANE_W-1:0] rlane;
  logic [WORD_W-1:0] lane_rd [LANES];
  logic [WORD_W-1:0] rd_d;

  assign off    = rd_addr - LOC_BASE;
  assign in_rng = (off < 32'(TOT_B));
  assign widx   = off >> WB_SH;
  assign rlane  = widx[LANE_W-1:0];
  assign rbeat  = BIW'(widx >> LANE_W);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] mem [BEATS];
    always_ff @(posedge wclk) begin
      if (wr_en) mem[wr_beat] <= wr_data[l*WORD_W +: WORD_W];
    end
    assign lane_rd[l] = mem[rbeat];
  end

  always_comb begin
    rd_d = rd_data;
    if (rd_en) rd_d = in_rng ? lane_rd[rlane] : '0;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rd_data <= '0;
    else         rd_data <= rd_d;
  end

  AST_RD_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_en |=> $stable(rd_data)); // R7

  AST_OOR_ZERO: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && !in_rng) |=> (rd_data == '0)); // R8

endmodule

// File: rtl/tex_prefill_cache.sv
module tex_prefill_cache #(
  parameter int          ADDR_W   = 32,
  parameter int          CNT_W    = 32,
  parameter int          ID_W     = 4,
  parameter int          BEATS    = 8,
  parameter int          BEAT_W   = 256,
  parameter int          WORD_W   = 32,
  parameter logic [31:0] SRC_BASE = 32'h0010_0000,
  parameter logic [31:0] LOC_BASE = 32'h0000_0800,
  parameter int          AXI_ID   = 3,
  localparam int         BIW      = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              mem_clk,
  input  logic              smp_clk,
  input  logic              rst_n,
  input  logic              load_trig,
  output logic              load_done,
  output logic [CNT_W-1:0]  load_beats,
  output logic [CNT_W-1:0]  load_bytes,
  output logic [CNT_W-1:0]  load_errs,
  output logic [ADDR_W-1:0] araddr,
  output logic [ID_W-1:0]   arid,
  output logic [7:0]        arlen,
  output logic [2:0]        arsize,
  output logic [1:0]        arburst,
  output logic              arvalid,
  input  logic              arready,
  input  logic [BEAT_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rvalid,
  output logic              rready,
  input  logic              smp_rd_en,
  input  logic [31:0]       smp_rd_addr,
  output logic [WORD_W-1:0] smp_rd_data,
  output logic              smp_ready
);

  logic           mem_rst_n, smp_rst_n;
  logic           wr_en;
  logic [BIW-1:0] wr_beat;

  tpc_sync u_mem_rst (.clk(mem_clk), .arst_n(rst_n), .d(1'b1), .q(mem_rst_n));
  tpc_sync u_smp_rst (.clk(smp_clk), .arst_n(rst_n), .d(1'b1), .q(smp_rst_n));

  tpc_fill_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_W(ID_W), .BEATS(BEATS),
    .BEAT_W(BEAT_W), .SRC_BASE(SRC_BASE), .AXI_ID(AXI_ID)
  ) u_ctrl (
    .clk(mem_clk), .rst_n(mem_rst_n), .trig(load_trig),
    .done(load_done), .beats(load_beats), .bytes(load_bytes), .errs(load_errs),
    .araddr(araddr), .arid(arid), .arlen(arlen), .arsize(arsize),
    .arburst(arburst), .arvalid(arvalid), .arready(arready),
    .rvalid(rvalid), .rresp(rresp), .rready(rready),
    .wr_en(wr_en), .wr_beat(wr_beat)
  );

  tpc_word_ram #(
    .BEATS(BEATS), .BEAT_W(BEAT_W), .WORD_W(WORD_W), .LOC_BASE(LOC_BASE)
  ) u_ram (
    .wclk(mem_clk), .wr_en(wr_en), .wr_beat(wr_beat), .wr_data(rdata),
    .rclk(smp_clk), .rrst_n(smp_rst_n), .rd_en(smp_rd_en),
    .rd_addr(smp_rd_addr), .rd_data(smp_rd_data)
  );

  tpc_sync u_rdy_sync (.clk(smp_clk), .arst_n(smp_rst_n), .d(load_done), .q(smp_ready));

endmodule

// File: tb/tex_prefill_cache_tb_top.sv
module tex_prefill_cache_tb_top;

  localparam logic [31:0] SRC = 32'h0010_0000;
  localparam logic [31:0] LOC = 32'h0000_0800;
  localparam int          NB  = 8;

  logic mem_clk, smp_clk, rst_n, load_trig;
  logic load_done, arvalid, arready, rvalid, rready, smp_rd_en, smp_ready;
  logic [31:0] load_beats, load_bytes, load_errs, araddr, smp_rd_addr, smp_rd_data;
  logic [3:0] arid;
  logic [7:0] arlen;
  logic [2:0] arsize;
  logic [1:0] arburst, rresp;
  logic [255:0] rdata;

  int n_chk = 0, n_err = 0, hs_cnt = 0, exp_beat = 0, err_beat = -1, dly = 0;
  bit m_busy = 0, finished = 0;

  tex_prefill_cache #(.SRC_BASE(SRC), .LOC_BASE(LOC), .AXI_ID(3)) dut_i (
    .mem_clk(mem_clk), .smp_clk(smp_clk), .rst_n(rst_n), .load_trig(load_trig),
    .load_done(load_done), .load_beats(load_beats), .load_bytes(load_bytes),
    .load_errs(load_errs), .araddr(araddr), .arid(arid), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .smp_rd_en(smp_rd_en), .smp_rd_addr(smp_rd_addr), .smp_rd_data(smp_rd_data),
    .smp_ready(smp_ready)
  );

  initial begin mem_clk = 0; forever #2ns mem_clk = ~mem_clk; end
  initial begin smp_clk = 0; forever #3.5ns smp_clk = ~smp_clk; end

  function automatic logic [31:0] tw(input int i);
    return 32'hCAFE_0000 + 32'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: grants each request, answers one beat a few cycles later
  always @(posedge mem_clk or negedge rst_n) begin
    if (!rst_n) begin
      arready <= 1'b0; rvalid <= 1'b0; rresp <= 2'b00; rdata <= '0;
      m_busy = 0; dly = 0;
    end else begin
      arready <= 1'b0;
      rvalid  <= 1'b0;
      if (!m_busy && arvalid && !arready) begin
        arready <= 1'b1;
        chk(araddr == SRC + 32'(exp_beat) * 32, "R2 address", araddr, SRC + 32'(exp_beat) * 32);
        chk({arlen, arsize, arburst, arid} == {8'd0, 3'd5, 2'b01, 4'd3}, "R2 request fields",
            32'({arlen, arsize, arburst, arid}), 32'({8'd0, 3'd5, 2'b01, 4'd3}));
        m_busy = 1; dly = 2; hs_cnt++;
      end else if (m_busy) begin
        if (dly != 0) dly--;
        else if (rready) begin
          for (int l = 0; l < 8; l++) rdata[l*32 +: 32] <= tw(exp_beat * 8 + l);
          rresp  <= (exp_beat == err_beat) ? 2'b10 : 2'b00;
          rvalid <= 1'b1;
          m_busy = 0;
          exp_beat = (exp_beat == NB - 1) ? 0 : exp_beat + 1;
        end
      end
    end
  end

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge smp_clk); smp_rd_en = 1'b1; smp_rd_addr = a;
    @(negedge smp_clk); smp_rd_en = 1'b0; d = smp_rd_data;
  endtask

  task automatic wait_mem(input int n);
    repeat (n) @(negedge mem_clk);
  endtask

  // toggle the trigger, see done drop and ready drop, then wait for completion
  task automatic do_fill();
    int g;
    @(negedge mem_clk); load_trig = ~load_trig;
    g = 0; while (load_done && g < 50) begin @(negedge mem_clk); g++; end
    chk(!load_done, "R4 done cleared by new fill", 32'(load_done), 0);
    repeat (4) @(negedge smp_clk);
    chk(!smp_ready, "R9 ready low during fill", 32'(smp_ready), 0);
    g = 0; while (!load_done && g < 2000) begin @(negedge mem_clk); g++; end
  endtask

  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0800, 32'hCAFE_0000},
    {32'h0000_0804, 32'hCAFE_0001},
    {32'h0000_081C, 32'hCAFE_0007},
    {32'h0000_0820, 32'hCAFE_0008},
    {32'h0000_08FC, 32'hCAFE_003F},
    {32'h0000_0806, 32'hCAFE_0001},
    {32'h0000_0900, 32'h0000_0000},
    {32'h0000_07FC, 32'h0000_0000}
  };

  initial begin
    logic [31:0] d;
    int g, base;
    rst_n = 0; load_trig = 0; smp_rd_en = 0; smp_rd_addr = '0;
    #20ns rst_n = 1;
    wait_mem(12);

    // R1 reset state
    chk(!load_done && load_beats == 0 && load_bytes == 0 && load_errs == 0, "R1 counters",
        load_beats | load_bytes | load_errs | 32'(load_done), 0);
    chk(!arvalid && hs_cnt == 0, "R1 no request", 32'(hs_cnt), 0);
    chk(!smp_ready && smp_rd_data == 0, "R1 sampler side", smp_rd_data, 0);

    // first fill on a rising edge
    @(negedge mem_clk); load_trig = 1'b1;
    g = 0; while (!load_done && g < 2000) begin @(negedge mem_clk); g++; end
    chk(load_done, "R4 done", 32'(load_done), 1);
    chk(load_beats == 8, "R4 beats", load_beats, 8);
    chk(load_bytes == 256, "R4 bytes", load_bytes, 256);
    chk(load_errs == 0, "R5 clean", load_errs, 0);
    chk(hs_cnt == 8, "R2 request count", 32'(hs_cnt), 8);
    g = 0; while (!smp_ready && g < 50) begin @(negedge smp_clk); g++; end
    chk(smp_ready, "R9 ready after fill", 32'(smp_ready), 1);

    // vector table: in-range, unaligned and out-of-range addresses
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][63:32], d);
      chk(d == VEC[i][31:0], (i >= 6) ? "R8 out of range" : "R6 vector", d, VEC[i][31:0]);
    end
    // full sweep of the cached words
    for (int i = 0; i < 64; i++) begin
      rd(LOC + 32'(i) * 4, d);
      chk(d == tw(i), "R6 sweep", d, tw(i));
    end

    // R7 registered timing and hold
    rd(LOC + 4, d);
    @(negedge smp_clk); smp_rd_en = 1'b1; smp_rd_addr = LOC + 8;
    #1ns chk(smp_rd_data == tw(1), "R7 not before edge", smp_rd_data, tw(1));
    @(negedge smp_clk); smp_rd_en = 1'b0; smp_rd_addr = LOC + 12;
    chk(smp_rd_data == tw(2), "R7 after edge", smp_rd_data, tw(2));
    repeat (2) @(negedge smp_clk);
    chk(smp_rd_data == tw(2), "R7 hold while idle", smp_rd_data, tw(2));

    // R5 error beat, on a falling trigger edge (R3)
    err_beat = 3;
    do_fill();
    chk(load_errs == 1, "R5 one error beat", load_errs, 1);
    chk(hs_cnt == 16, "R3 falling edge fill", 32'(hs_cnt), 16);
    err_beat = -1;
    do_fill();
    chk(load_errs == 0, "R5 cleared on new fill", load_errs, 0);

    // R3 pulse during fill gives two fills
    base = hs_cnt;
    @(negedge mem_clk); load_trig = ~load_trig;
    wait_mem(3);
    load_trig = ~load_trig;
    g = 0; while (!(hs_cnt == base + 16 && load_done) && g < 4000) begin @(negedge mem_clk); g++; end
    wait_mem(20);
    chk(hs_cnt - base == 16, "R3 pulse makes two fills", 32'(hs_cnt - base), 16);
    chk(load_done && load_beats == 8, "R4 after pulse", load_beats, 8);
    g = 0; while (!smp_ready && g < 50) begin @(negedge smp_clk); g++; end
    rd(LOC + 32'd100, d);
    chk(d == tw(25), "R6 after refill", d, tw(25));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #300us;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule